// File: doc/BRIEF.md
# ADC Conversion Scan Sequencer

This block schedules conversions for an external 12-bit analog-to-digital converter. Software fills a channel-enable mask that covers channels 0 to 7 and channel 10, picks a mode and sets a start bit. The sequencer then walks the enabled channels in ascending order. For each channel it gives the converter a one-cycle start pulse with a channel number, waits for the converter's done strobe, and stores the returned sample in that channel's result slot.

Three modes are available. Single mode converts only the lowest enabled channel. One-pass scan converts every enabled channel once. Looping scan repeats passes until software clears the start bit. Each result slot keeps a fresh-data flag and a lost-data flag, and reading the slot clears both. An end-of-pass flag is cleared by writing 1 to it, and it can drive an interrupt line.

Register access uses a simple strobe bus. A write takes effect at the clock edge that samples it. Read data appears on `rd_data` one cycle after `rd_en`. Register addresses are CTRL=0, MASK=1, STATUS=2, and result slots start at 16. Slot s holds channel s for s<8, and slot 8 holds channel 10.

Top module: `adc_scan_seq`

## Requirements
- R1: CTRL (address 0) holds start in bit 0, mode in bits 2:1 and interrupt enable in bit 3. In mode 0 (single), and in the reserved mode 1, only the lowest enabled channel is converted once. Hardware then clears start, keeps the mode bits, and sets the end flag.
- R2: MASK (address 1) bits 7:0 enable channels 0 to 7 and bit 8 enables channel 10. In mode 2, each enabled channel is converted once in ascending order, with channel 10 last. After the pass, start is cleared and the end flag is set.
- R3: In mode 3, ascending passes repeat for as long as start stays 1. The end flag is set after every pass. After software writes 0 to start, no further conversion is issued.
- R4: Writing 0 to start while a conversion is in flight lets that handshake finish and stores its result. The sequencer then goes idle without setting the end flag.
- R5: `conv_start` is a one-cycle pulse, and `conv_chan` is valid with it and holds until the next pulse. No new pulse is issued before `conv_done`, which captures `conv_data` into the channel's slot.
- R6: STATUS (address 2) bit 1 is busy while a sequence is active, and bits 7:4 hold the channel number being converted.
- R7: STATUS bit 0 is the end flag, and writing 1 to bit 0 clears it. If the flag is set in the same cycle as such a write, the set wins.
- R8: `irq` is high exactly when the interrupt enable bit and the end flag are both 1.
- R9: STATUS bits 16:8 are per-slot fresh flags, set when a conversion completes. Reading slot address 16+s returns the 12-bit result in bits 11:0 and clears both flags of slot s.
- R10: STATUS bits 25:17 are per-slot overrun flags, set when a conversion for a slot completes while its fresh flag is high. If a read of that slot falls in the same cycle, the read returns the old result, the fresh flag stays set and the overrun flag is left clear.
- R11: After reset, all registers and flags read 0, and `conv_start` and `irq` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | 32 | Read data, one cycle after rd_en |
| conv_start | output | 1 | Start pulse to converter |
| conv_chan | output | 4 | Channel number for the conversion |
| conv_done | input | 1 | Converter completion strobe |
| conv_data | input | RES_W | Converter sample, valid with conv_done |
| irq | output | 1 | End-of-pass interrupt |

## Verification
A result-slot read can land in the same cycle as a completion for that slot. A W1C of the end flag can also coincide with a hardware set. The bench provokes both by taking the converter strobe under direct control. It raises `conv_done` at the same falling edge where it drives the slot read or the flag-clear write. For the read collision it expects the earlier sample on `rd_data`, the fresh flag still high and the overrun flag low. For the flag collision it expects the end flag to read back as set.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  localparam int LOW_CH   = 8;
  localparam int EXTRA_CH = 10;
  localparam int NSLOT    = LOW_CH + 1;
  localparam int SLOT_W   = $clog2(NSLOT);
  localparam int CH_W     = 4;

  typedef enum logic [1:0] {
    MODE_SINGLE = 2'd0,
    MODE_RSVD   = 2'd1,
    MODE_ONCE   = 2'd2,
    MODE_LOOP   = 2'd3
  } scan_mode_e;

  function automatic logic [CH_W-1:0] slot_chan(input logic [SLOT_W-1:0] slot);
    if (int'(slot) < LOW_CH) return CH_W'(slot);
    return CH_W'(EXTRA_CH);
  endfunction
endpackage

// File: rtl/adc_seq_store.sv
module adc_seq_store
  import adc_seq_pkg::*;
#(
  parameter int RES_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [SLOT_W-1:0] widx,
  input  logic [RES_W-1:0]  wdata,
  input  logic              rd_en,
  input  logic              rd_hit,
  input  logic [SLOT_W-1:0] ridx,
  output logic [RES_W-1:0]  rdata,
  output logic [NSLOT-1:0]  fresh,
  output logic [NSLOT-1:0]  lost
);
  logic [RES_W-1:0] mem [NSLOT];

  // plain dual-port array, read-first, no reset: maps to block RAM
  always_ff @(posedge clk) begin
    if (we) mem[widx] <= wdata;
    if (rd_en && rd_hit) rdata <= mem[ridx];
  end

  for (genvar s = 0; s < NSLOT; s++) begin : g_flag
    logic set_s, clr_s;
    assign set_s = we && (widx == SLOT_W'(s));
    assign clr_s = rd_en && rd_hit && (ridx == SLOT_W'(s));

    always_ff @(posedge clk) begin
      if (rst) begin
        fresh[s] <= 1'b0;
        lost[s]  <= 1'b0;
      end else if (set_s) begin
        fresh[s] <= 1'b1;
        lost[s]  <= clr_s ? 1'b0 : (lost[s] | fresh[s]);
      end else if (clr_s) begin
        fresh[s] <= 1'b0;
        lost[s]  <= 1'b0;
      end
    end

    assert_ovr_implies_valid_R9: assert property (@(posedge clk) disable iff (rst)
      lost[s] |-> fresh[s]);
    assert_ovr_needs_prior_R10: assert property (@(posedge clk) disable iff (rst)
      $rose(lost[s]) |-> $past(fresh[s]));
  end
endmodule

// File: rtl/adc_seq_fsm.sv
module adc_seq_fsm
  import adc_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  scan_mode_e        mode,
  input  logic [NSLOT-1:0]  mask,
  input  logic              conv_done,
  output logic              conv_start,
  output logic [CH_W-1:0]   conv_chan,
  output logic              busy,
  output logic              slot_we,
  output logic [SLOT_W-1:0] slot_idx,
  output logic              pass_done,
  output logic              hw_stop
);
  typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_WAIT} seq_state_e;
  seq_state_e        state;
  logic [SLOT_W-1:0] cur;
  logic              first_ok, nxt_ok, done_hit, single, looping;
  logic [SLOT_W-1:0] first_idx, nxt_idx;

  always_comb begin
    first_ok  = 1'b0;
    first_idx = '0;
    nxt_ok    = 1'b0;
    nxt_idx   = '0;
    for (int i = NSLOT - 1; i >= 0; i--) begin
      if (mask[i]) begin
        first_ok  = 1'b1;
        first_idx = SLOT_W'(i);
      end
      if (mask[i] && (SLOT_W'(i) > cur)) begin
        nxt_ok  = 1'b1;
        nxt_idx = SLOT_W'(i);
      end
    end
  end

  assign single   = ~mode[1];
  assign looping  = (mode == MODE_LOOP);
  assign done_hit = (state == S_WAIT) && conv_done;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= S_IDLE;
      cur   <= '0;
    end else begin
      case (state)
        S_IDLE: if (run && first_ok) begin
          cur   <= first_idx;
          state <= S_ISSUE;
        end
        S_ISSUE: state <= S_WAIT;
        S_WAIT: if (conv_done) begin
          if (!run || single) state <= S_IDLE;
          else if (nxt_ok) begin
            cur   <= nxt_idx;
            state <= S_ISSUE;
          end else if (looping && first_ok) begin
            cur   <= first_idx;
            state <= S_ISSUE;
          end else state <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign conv_start = (state == S_ISSUE);
  assign conv_chan  = slot_chan(cur);
  assign busy       = (state != S_IDLE);
  assign slot_we    = done_hit;
  assign slot_idx   = cur;
  assign pass_done  = done_hit && run && (single || !nxt_ok);
  assign hw_stop    = done_hit && run && (single || (!nxt_ok && !(looping && first_ok)));

  assert_start_pulse_R5: assert property (@(posedge clk) disable iff (rst)
    conv_start |=> !conv_start);
  assert_chan_legal_R2: assert property (@(posedge clk) disable iff (rst)
    conv_start |-> ((conv_chan < CH_W'(LOW_CH)) || (conv_chan == CH_W'(EXTRA_CH))));
endmodule

// File: rtl/adc_seq_regs.sv
module adc_seq_regs
  import adc_seq_pkg::*;
#(
  parameter int ADDR_W   = 5,
  parameter int RES_BASE = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [31:0]       wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic              hw_stop,
  input  logic              pass_done,
  input  logic              busy,
  input  logic [CH_W-1:0]   cur_chan,
  input  logic [NSLOT-1:0]  fresh,
  input  logic [NSLOT-1:0]  lost,
  output logic              run,
  output scan_mode_e        mode,
  output logic              irq_en,
  output logic [NSLOT-1:0]  mask,
  output logic              eoc,
  output logic [31:0]       reg_rdata,
  output logic              res_sel,
  output logic              rd_res_hit,
  output logic [SLOT_W-1:0] rd_res_idx
);
  localparam logic [ADDR_W-1:0] A_CTRL    = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_MASK    = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_STAT    = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_RES     = ADDR_W'(RES_BASE);
  localparam logic [ADDR_W-1:0] A_RES_END = ADDR_W'(RES_BASE + NSLOT);
  localparam int FRESH_LSB = 8;
  localparam int LOST_LSB  = FRESH_LSB + NSLOT;

  logic              ctrl_wr, mask_wr, stat_wr;
  logic [ADDR_W-1:0] res_off;
  logic [31:0]       status;

  assign ctrl_wr = wr_en && (wr_addr == A_CTRL);
  assign mask_wr = wr_en && (wr_addr == A_MASK);
  assign stat_wr = wr_en && (wr_addr == A_STAT);

  always_ff @(posedge clk) begin
    if (rst) begin
      run    <= 1'b0;
      mode   <= MODE_SINGLE;
      irq_en <= 1'b0;
      mask   <= '0;
      eoc    <= 1'b0;
    end else begin
      if (ctrl_wr) begin
        run    <= wr_data[0];
        mode   <= scan_mode_e'(wr_data[2:1]);
        irq_en <= wr_data[3];
      end else if (hw_stop) begin
        run <= 1'b0;
      end
      if (mask_wr) mask <= wr_data[NSLOT-1:0];
      if (pass_done) eoc <= 1'b1;
      else if (stat_wr && wr_data[0]) eoc <= 1'b0;
    end
  end

  always_comb begin
    status = '0;
    status[0] = eoc;
    status[1] = busy;
    status[7:4] = cur_chan;
    status[FRESH_LSB +: NSLOT] = fresh;
    status[LOST_LSB +: NSLOT] = lost;
  end

  assign res_off    = rd_addr - A_RES;
  assign rd_res_idx = res_off[SLOT_W-1:0];
  assign rd_res_hit = (rd_addr >= A_RES) && (rd_addr < A_RES_END);

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
      res_sel   <= 1'b0;
    end else if (rd_en) begin
      res_sel <= rd_res_hit;
      case (rd_addr)
        A_CTRL:  reg_rdata <= {28'd0, irq_en, mode, run};
        A_MASK:  reg_rdata <= 32'(mask);
        A_STAT:  reg_rdata <= status;
        default: reg_rdata <= '0;
      endcase
    end
  end

  logic unused_bits;
  assign unused_bits = ^{wr_data[31:NSLOT], res_off};

  assert_hw_stop_R3: assert property (@(posedge clk) disable iff (rst)
    hw_stop |-> ((mode != MODE_LOOP) || (mask == '0)));
  assert_eoc_set_R7: assert property (@(posedge clk) disable iff (rst)
    pass_done |=> eoc);
endmodule

// File: rtl/adc_scan_seq.sv
module adc_scan_seq
  import adc_seq_pkg::*;
#(
  parameter int ADDR_W   = 5,
  parameter int RES_W    = 12,
  parameter int RES_BASE = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [31:0]       wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [31:0]       rd_data,
  output logic              conv_start,
  output logic [3:0]        conv_chan,
  input  logic              conv_done,
  input  logic [RES_W-1:0]  conv_data,
  output logic              irq
);
  logic              run, irq_en, eoc, busy, slot_we, pass_done, hw_stop;
  logic              res_sel, rd_res_hit;
  scan_mode_e        mode;
  logic [NSLOT-1:0]  mask, fresh, lost;
  logic [SLOT_W-1:0] slot_idx, rd_res_idx;
  logic [31:0]       reg_rdata;
  logic [RES_W-1:0]  res_rdata;

  adc_seq_regs #(.ADDR_W(ADDR_W), .RES_BASE(RES_BASE)) u_regs (
    .clk, .rst, .wr_en, .wr_addr, .wr_data, .rd_en, .rd_addr,
    .hw_stop, .pass_done, .busy, .cur_chan(conv_chan), .fresh, .lost,
    .run, .mode, .irq_en, .mask, .eoc, .reg_rdata, .res_sel,
    .rd_res_hit, .rd_res_idx
  );

  adc_seq_fsm u_fsm (
    .clk, .rst, .run, .mode, .mask, .conv_done, .conv_start, .conv_chan,
    .busy, .slot_we, .slot_idx, .pass_done, .hw_stop
  );

  adc_seq_store #(.RES_W(RES_W)) u_store (
    .clk, .rst, .we(slot_we), .widx(slot_idx), .wdata(conv_data),
    .rd_en, .rd_hit(rd_res_hit), .ridx(rd_res_idx), .rdata(res_rdata),
    .fresh, .lost
  );

  assign rd_data = res_sel ? 32'(res_rdata) : reg_rdata;
  assign irq     = irq_en & eoc;
endmodule

// File: tb/sim_adc_scan_seq.sv
module sim_adc_scan_seq;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [4:0]  wr_addr = '0, rd_addr = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        conv_start, conv_done, irq;
  logic [3:0]  conv_chan;
  logic [11:0] conv_data;

  logic        manual = 1'b0;
  logic        man_done = 1'b0, auto_done = 1'b0;
  logic [11:0] man_data = '0, auto_data = '0;
  int          lat = 3;
  int          log_n = 0;
  int          seq = 0;
  logic [3:0]  log_ch [64];
  logic [11:0] exp_res [9];
  int          n_chk = 0, n_err = 0;

  assign conv_done = manual ? man_done : auto_done;
  assign conv_data = manual ? man_data : auto_data;

  always #5 clk = ~clk;

  adc_scan_seq u0 (
    .clk, .rst, .wr_en, .wr_addr, .wr_data, .rd_en, .rd_addr, .rd_data,
    .conv_start, .conv_chan, .conv_done, .conv_data, .irq
  );

  function automatic int slot_of(input logic [3:0] ch);
    return (ch == 4'd10) ? 8 : int'(ch);
  endfunction

  // converter model
  initial forever begin
    @(negedge clk);
    auto_done = 1'b0;
    if (!manual && conv_start) begin
      if (log_n < 64) log_ch[log_n] = conv_chan;
      log_n++;
      seq++;
      repeat (lat - 1) @(negedge clk);
      auto_data = {conv_chan, 8'(seq)};
      exp_res[slot_of(conv_chan)] = auto_data;
      auto_done = 1'b1;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    rd_en = 1'b1; rd_addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rd_data;
  endtask

  task automatic wait_idle();
    logic [31:0] s;
    repeat (3) @(negedge clk);
    for (int i = 0; i < 2000; i++) begin
      rd(5'd2, s);
      if (!s[1]) break;
    end
  endtask

  task automatic wait_start();
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (conv_start) break;
    end
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk("R11 conv_start", 32'(conv_start), 0);
    chk("R11 irq", 32'(irq), 0);
    rd(5'd0, d); chk("R11 ctrl", d, 0);
    rd(5'd1, d); chk("R11 mask", d, 0);
    rd(5'd2, d); chk("R11 status", d, 0);
  endtask

  task automatic t_single();
    logic [31:0] d;
    log_n = 0;
    wr(5'd1, 32'h0A4);
    wr(5'd0, 32'h1);
    wait_idle();
    chk("R1 single count", 32'(log_n), 1);
    chk("R1 single lowest", 32'(log_ch[0]), 2);
    rd(5'd0, d); chk("R1 start cleared", d, 0);
    rd(5'd2, d); chk("R1 status", d, 32'h1 | (32'd2 << 4) | (32'd1 << 10));
    log_n = 0;
    wr(5'd1, 32'h030);
    wr(5'd0, 32'h3);
    wait_idle();
    chk("R1 reserved count", 32'(log_n), 1);
    chk("R1 reserved lowest", 32'(log_ch[0]), 4);
    rd(5'd0, d); chk("R1 reserved ctrl", d, 32'h2);
  endtask

  task automatic t_irq();
    chk("R8 irq off", 32'(irq), 0);
    wr(5'd0, 32'h8);
    chk("R8 irq on", 32'(irq), 1);
    wr(5'd2, 32'h1);
    chk("R8 irq after clear", 32'(irq), 0);
    wr(5'd0, 32'h0);
  endtask

  task automatic t_read();
    logic [31:0] d;
    rd(5'd18, d); chk("R9 slot2 data", d, 32'(exp_res[2]));
    rd(5'd2, d);
    chk("R9 fresh after read", 32'((d >> 8) & 32'h1FF), 32'h010);
    chk("R7 eoc cleared", 32'(d[0]), 0);
  endtask

  task automatic t_scan();
    logic [31:0] d;
    log_n = 0;
    wr(5'd1, 32'h10A);
    wr(5'd0, 32'h5);
    wait_idle();
    chk("R2 count", 32'(log_n), 3);
    chk("R2 ch a", 32'(log_ch[0]), 1);
    chk("R2 ch b", 32'(log_ch[1]), 3);
    chk("R5 ch10 number", 32'(log_ch[2]), 10);
    rd(5'd0, d); chk("R2 ctrl", d, 32'h4);
    rd(5'd2, d); chk("R2 eoc", 32'(d[0]), 1);
    rd(5'd24, d); chk("R5 slot8 data", d, 32'(exp_res[8]));
  endtask

  task automatic t_overrun();
    logic [31:0] d;
    wr(5'd0, 32'h5);
    wait_idle();
    rd(5'd2, d);
    chk("R10 overrun", 32'((d >> 17) & 32'h1FF), 32'h00A);
    chk("R9 fresh", 32'((d >> 8) & 32'h1FF), 32'h11A);
    rd(5'd17, d); chk("R9 slot1 data", d, 32'(exp_res[1]));
    rd(5'd2, d);
    chk("R9 overrun after read", 32'((d >> 17) & 32'h1FF), 32'h008);
    chk("R9 fresh after read", 32'((d >> 8) & 32'h1FF), 32'h118);
  endtask

  task automatic t_loop();
    logic [31:0] d;
    int n;
    wr(5'd2, 32'h1);
    log_n = 0;
    wr(5'd1, 32'h041);
    wr(5'd0, 32'h7);
    for (int i = 0; i < 1000 && log_n < 5; i++) @(negedge clk);
    rd(5'd2, d);
    chk("R6 busy", 32'(d[1]), 1);
    chk("R6 channel", 32'((d[7:4] == 4'd0) || (d[7:4] == 4'd6)), 1);
    chk("R3 eoc per pass", 32'(d[0]), 1);
    wr(5'd0, 32'h6);
    wait_idle();
    n = log_n;
    repeat (20) @(negedge clk);
    chk("R3 stopped", 32'(log_n), 32'(n));
    for (int i = 0; i < 5; i++)
      chk("R3 order", 32'(log_ch[i]), (i % 2 == 1) ? 32'd6 : 32'd0);
  endtask

  task automatic t_abort();
    logic [31:0] d;
    wr(5'd2, 32'h1);
    lat = 8;
    log_n = 0;
    wr(5'd1, 32'h0FF);
    wr(5'd0, 32'h5);
    for (int i = 0; i < 100 && log_n < 1; i++) @(negedge clk);
    wr(5'd0, 32'h4);
    wait_idle();
    repeat (10) @(negedge clk);
    chk("R4 single handshake", 32'(log_n), 1);
    rd(5'd2, d); chk("R4 no eoc", 32'(d[0]), 0);
    rd(5'd16, d); chk("R4 result stored", d, 32'(exp_res[0]));
    lat = 3;
  endtask

  task automatic t_collide();
    logic [31:0] d;
    manual = 1'b1;
    wr(5'd1, 32'h010);
    wr(5'd0, 32'h1);
    wait_start();
    @(negedge clk);
    chk("R5 pulse width", 32'(conv_start), 0);
    chk("R5 chan held", 32'(conv_chan), 4);
    man_done = 1'b1; man_data = 12'h5A1;
    @(negedge clk);
    man_done = 1'b0;
    wr(5'd2, 32'h1);
    wr(5'd0, 32'h1);
    wait_start();
    @(negedge clk);
    man_done = 1'b1; man_data = 12'hB72;
    rd_en = 1'b1; rd_addr = 5'd20;
    wr_en = 1'b1; wr_addr = 5'd2; wr_data = 32'h1;
    @(negedge clk);
    man_done = 1'b0; rd_en = 1'b0; wr_en = 1'b0;
    chk("R10 read returns old", rd_data, 32'h5A1);
    rd(5'd2, d);
    chk("R7 set wins", 32'(d[0]), 1);
    chk("R10 fresh kept", 32'(d[12]), 1);
    chk("R10 overrun clear", 32'(d[21]), 0);
    rd(5'd20, d); chk("R9 new data", d, 32'hB72);
    rd(5'd2, d); chk("R9 fresh cleared", 32'(d[12]), 0);
    manual = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_single();
    t_irq();
    t_read();
    t_scan();
    t_overrun();
    t_loop();
    t_abort();
    t_collide();
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule